// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block sits between the bus and an on-chip flash array. It watches write cycles to the array and recognises multi-cycle command sequences: a two-write unlock pair, program word, block erase with a collection window, chip erase, erase suspend, erase resume and read/reset. The recognised commands drive an erase/program controller. That controller issues start requests to an array timer and waits for the timer's done or fail pulse. Any malformed sequence is thrown away, and the interface falls back to read mode.

An erase runs one block at a time, in ascending block order. Each block is first programmed to all zeros and then erased to all ones. While an erase or a collection window is in progress, only a small set of commands is honoured. A suspended erase can be resumed, abandoned, or interleaved with program operations on blocks that are not in the erase set. The command byte is always the low data byte. The block index is the top `BLK_W` address bits.

Sequence decoder states: `D_IDLE`, `D_U1` (first unlock write seen), `D_U2` (unlock pair complete), `D_PGM` (waiting for the program word), `D_EE` (erase enabled), `D_EU1`, `D_EU2` (second unlock pair).
- Unlock pair: AAh at 2A54h, then 55h at 1554h, with addresses compared on the low 14 bits.
- From `D_U2`: A0h at 2A54h leads to program; 80h at 1554h leads to erase enable.
- From `D_EU2`: 10h at 1554h is chip erase; 30h at any address is block erase.
- F0h returns the decoder to `D_IDLE` from every state except `D_PGM`.

Controller states:
- `C_READ`: idle.
- `C_PROG`: program word busy.
- `C_TMO`: erase collection window.
- `C_PREP`: pre-program to zero.
- `C_ERAS`: erase to ones.
- `C_SUSP`: suspended.
- `C_SPRG`: program word during suspend.
- `C_ERR`: failure, showing status.

Controller transitions:
- `C_READ` goes to `C_PROG` on program, to `C_TMO` on block erase, and to `C_PREP` on chip erase.
- `C_TMO` goes to `C_PREP` on expiry, to `C_SUSP` on B0h, and to `C_READ` on F0h.
- `C_PREP` goes to `C_ERAS` on done.
- `C_ERAS` goes to `C_PREP` on done when more blocks remain, and to `C_READ` on done for the last block.
- `C_PREP` and `C_ERAS` go to `C_SUSP` on B0h, to `C_READ` on F0h, and to `C_ERR` on fail.
- `C_SUSP` goes to `C_PREP` or `C_ERAS` on 30h, to `C_SPRG` on a legal program, and to `C_READ` on F0h.
- `C_SPRG` goes to `C_SUSP` on done.
- `C_PROG` goes to `C_READ` on done.
- `C_PROG` and `C_SPRG` go to `C_ERR` on fail.
- `C_ERR` goes to `C_READ` on F0h.

Top module: `fcmd_top`

## Requirements
- R1: After reset, mode_o is 0 (read), start_o, susp_o and abort_o are low, and bad_o is all zero.
- R2: The program sequence is AAh at 2A54h, 55h at 1554h, A0h at 2A54h, then any write. That write raises start_o for one cycle with op_o=1 and blk_o=addr_i[15:13]. mode_o is 1 (busy) until done_i, then 0.
- R3: A wrong address or data byte in the middle of a sequence pulses abort_o for one cycle, returns the decoder to idle and leaves mode_o at 0.
- R4: Chip erase is six writes: the unlock pair, 80h at 1554h (upper data byte ignored), the unlock pair, then 10h at 1554h. The following cycle shows start_o with op_o=2 for block 0.
- R5: Block erase ends with 30h at any address in the target block, which opens a TMO_CYC-cycle window. In the window, each further 30h write adds its block and restarts the window. The first start_o comes exactly TMO_CYC cycles after the last such write.
- R6: Each block in the erase set is handled in ascending order. First comes a start with op_o=2 (zeros), then, after done_i, a start with op_o=3 (ones). The done_i for the last block's op_o=3 returns mode_o to 0.
- R7: While an erase runs, only B0h and F0h writes have an effect; in the window 30h also acts. Every other write, including an unlock write, leaves mode_o and abort_o unchanged.
- R8: B0h during the window or a running erase pulses susp_o and sets mode_o to 2. No start follows while suspended.
- R9: In suspend, 30h with the decoder idle resumes: it restarts the interrupted phase (op_o 2 or 3, or op_o 2 if suspended in the window) for the current block. An attempt to enable erase is rejected with abort_o.
- R10: In suspend, a program word to a block outside the erase set starts op_o=1 and returns to mode_o=2 on done_i. A program word to a block in the set pulses abort_o and starts nothing.
- R11: F0h in suspend, or during a running pre-program or erase, pulses abort_o, returns to mode_o=0 and sets the current block's bit in bad_o. A completed erase of a block clears its bit.
- R12: fail_i while busy sets mode_o to 3 (status). Only F0h then returns mode_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | 16 | Word address of the write |
| data_i | input | 16 | Write data; low byte carries the command |
| done_i | input | 1 | Array timer: current operation finished |
| fail_i | input | 1 | Array timer: current operation failed |
| mode_o | output | 2 | 0 read, 1 busy, 2 suspended, 3 status |
| start_o | output | 1 | One-cycle request to start an array operation |
| op_o | output | 2 | Operation of the last start: 1 word, 2 zeros, 3 ones |
| blk_o | output | 3 | Block of the last start |
| susp_o | output | 1 | One-cycle pulse when an erase is suspended |
| abort_o | output | 1 | One-cycle pulse on a rejected sequence or abandoned erase |
| bad_o | output | 8 | Blocks left invalid by an abandoned erase |

## Verification
The bench goes after four kinds of corner case.
- Window restart: a second block confirm inside the window must restart it. A design that only adds the block would start one window too early, and the measured delay would be short.
- Suspend in the window: a suspend issued before any array operation starts must hold off every start. A design that lets the window run to expiry would produce an unexpected start in the scoreboard.
- Rejected program: a program to the suspended block must be rejected, while a program to another block must run and fall back to suspend. A design that misses the set check would corrupt the erased block.
- Reset and error recovery: an abort by read/reset must mark the block bad, and a chip erase must clear that mark. After a failure, writes other than F0h must not leave the status state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        MD_READ = 2'd0,
        MD_BUSY = 2'd1,
        MD_SUSP = 2'd2,
        MD_STAT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WORD = 2'd1,
        OP_ZERO = 2'd2,
        OP_ONES = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_PROG,
        EV_BERS,
        EV_CERS,
        EV_BAD
    } ev_e;

    localparam logic [13:0] KEY_ADDR_A = 14'h2A54;
    localparam logic [13:0] KEY_ADDR_B = 14'h1554;

    localparam logic [7:0] CB_KEY1 = 8'hAA;
    localparam logic [7:0] CB_KEY2 = 8'h55;
    localparam logic [7:0] CB_WORD = 8'hA0;
    localparam logic [7:0] CB_EEN  = 8'h80;
    localparam logic [7:0] CB_CHIP = 8'h10;
    localparam logic [7:0] CB_CONF = 8'h30;
    localparam logic [7:0] CB_SUSP = 8'hB0;
    localparam logic [7:0] CB_RST  = 8'hF0;

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ers_ok,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dat,
    output ev_e               ev,
    output logic              idle,
    output logic              pgm
);

    typedef enum logic [2:0] {D_IDLE, D_U1, D_U2, D_PGM, D_EE, D_EU1, D_EU2} dst_e;

    dst_e        st, nst;
    logic [13:0] a14;

    assign a14 = addr[13:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= D_IDLE;
        else        st <= nst;
    end

    always_comb begin
        nst = st;
        ev  = EV_NONE;
        if (!en) begin
            nst = D_IDLE;
        end else if (wr) begin
            if (dat == CB_RST && st != D_PGM) begin
                nst = D_IDLE;
            end else begin
                unique case (st)
                    D_IDLE: if (dat == CB_KEY1 && a14 == KEY_ADDR_A) nst = D_U1;
                    D_U1: begin
                        if (dat == CB_KEY2 && a14 == KEY_ADDR_B) nst = D_U2;
                        else begin nst = D_IDLE; ev = EV_BAD; end
                    end
                    D_U2: begin
                        if (dat == CB_WORD && a14 == KEY_ADDR_A) nst = D_PGM;
                        else if (ers_ok && dat == CB_EEN && a14 == KEY_ADDR_B) nst = D_EE;
                        else begin nst = D_IDLE; ev = EV_BAD; end
                    end
                    D_PGM: begin
                        nst = D_IDLE;
                        ev  = EV_PROG;
                    end
                    D_EE: begin
                        if (dat == CB_KEY1 && a14 == KEY_ADDR_A) nst = D_EU1;
                        else begin nst = D_IDLE; ev = EV_BAD; end
                    end
                    D_EU1: begin
                        if (dat == CB_KEY2 && a14 == KEY_ADDR_B) nst = D_EU2;
                        else begin nst = D_IDLE; ev = EV_BAD; end
                    end
                    D_EU2: begin
                        nst = D_IDLE;
                        if (dat == CB_CHIP && a14 == KEY_ADDR_B) ev = EV_CERS;
                        else if (dat == CB_CONF)                 ev = EV_BERS;
                        else                                     ev = EV_BAD;
                    end
                    default: nst = D_IDLE;
                endcase
            end
        end
    end

    assign idle = (st == D_IDLE);
    assign pgm  = (st == D_PGM);

endmodule

// File: rtl/fcmd_tmo.sv
module fcmd_tmo #(
    parameter int TMO_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);

    localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || restart)  cnt <= '0;
        else if (cnt != LAST)      cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/fcmd_blkset.sv
module fcmd_blkset #(
    parameter int BLK_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_all,
    input  logic                   set_all,
    input  logic                   add_en,
    input  logic [BLK_W-1:0]       add_blk,
    input  logic                   del_en,
    input  logic [BLK_W-1:0]       del_blk,
    output logic [(1<<BLK_W)-1:0]  set_v,
    output logic [BLK_W-1:0]       cur,
    output logic [BLK_W-1:0]       nxt,
    output logic                   last
);

    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] cur_oh;
    logic [NBLK-1:0] rest;

    function automatic logic [BLK_W-1:0] low_idx(input logic [NBLK-1:0] v);
        logic [BLK_W-1:0] r;
        r = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (v[i]) r = BLK_W'(i);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       set_v <= '0;
        else if (clr_all) set_v <= '0;
        else if (set_all) set_v <= '1;
        else begin
            if (add_en) set_v[add_blk] <= 1'b1;
            if (del_en) set_v[del_blk] <= 1'b0;
        end
    end

    assign cur = low_idx(set_v);

    generate
        for (genvar g = 0; g < NBLK; g++) begin : g_oh
            assign cur_oh[g] = (cur == BLK_W'(g));
        end
    endgenerate

    assign rest = set_v & ~cur_oh;
    assign nxt  = low_idx(rest);
    assign last = (rest == '0);

endmodule

// File: rtl/fcmd_top.sv
module fcmd_top
    import fcmd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BLK_W   = 3,
    parameter int TMO_CYC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [15:0]           data_i,
    input  logic                  done_i,
    input  logic                  fail_i,
    output logic [1:0]            mode_o,
    output logic                  start_o,
    output logic [1:0]            op_o,
    output logic [BLK_W-1:0]      blk_o,
    output logic                  susp_o,
    output logic                  abort_o,
    output logic [(1<<BLK_W)-1:0] bad_o
);

    localparam int NBLK = 1 << BLK_W;

    typedef enum logic [2:0] {
        C_READ, C_PROG, C_TMO, C_PREP, C_ERAS, C_SUSP, C_SPRG, C_ERR
    } cst_e;

    typedef enum logic [1:0] {PH_WIN, PH_ZERO, PH_ONES} ph_e;

    cst_e             st, nst;
    ph_e              ph, nph;
    logic             start_n, susp_n, abort_n;
    op_e              op_q, op_n;
    logic [BLK_W-1:0] blk_q, blk_n;
    logic [NBLK-1:0]  bad_q, bad_n;

    logic [7:0]       cb;
    logic [BLK_W-1:0] blk_in;
    ev_e              ev;
    logic             dec_idle, dec_pgm;
    logic             tmo_exp, tmo_restart;
    logic             clr_all, set_all, add_en, del_en;
    logic [NBLK-1:0]  set_v;
    logic [BLK_W-1:0] cur, nxt;
    logic             last;
    logic             rst_cmd;

    assign cb      = data_i[7:0];
    assign blk_in  = addr_i[ADDR_W-1 -: BLK_W];
    assign rst_cmd = wr_i && cb == CB_RST && !dec_pgm;

    fcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (st == C_READ || st == C_SUSP),
        .ers_ok (st == C_READ),
        .wr     (wr_i),
        .addr   (addr_i),
        .dat    (cb),
        .ev     (ev),
        .idle   (dec_idle),
        .pgm    (dec_pgm)
    );

    assign tmo_restart = (st == C_TMO) && wr_i && cb == CB_CONF;

    fcmd_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == C_TMO),
        .restart (tmo_restart),
        .expired (tmo_exp)
    );

    fcmd_blkset #(.BLK_W(BLK_W)) u_set (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .set_all (set_all),
        .add_en  (add_en),
        .add_blk (blk_in),
        .del_en  (del_en),
        .del_blk (cur),
        .set_v   (set_v),
        .cur     (cur),
        .nxt     (nxt),
        .last    (last)
    );

    always_comb begin
        nst     = st;
        nph     = ph;
        start_n = 1'b0;
        susp_n  = 1'b0;
        abort_n = 1'b0;
        op_n    = op_q;
        blk_n   = blk_q;
        bad_n   = bad_q;
        clr_all = 1'b0;
        set_all = 1'b0;
        add_en  = 1'b0;
        del_en  = 1'b0;
        unique case (st)
            C_READ: begin
                unique case (ev)
                    EV_PROG: begin
                        nst = C_PROG; start_n = 1'b1; op_n = OP_WORD; blk_n = blk_in;
                    end
                    EV_BERS: begin
                        nst = C_TMO; add_en = 1'b1;
                    end
                    EV_CERS: begin
                        nst = C_PREP; set_all = 1'b1;
                        start_n = 1'b1; op_n = OP_ZERO; blk_n = '0;
                    end
                    EV_BAD:  abort_n = 1'b1;
                    default: ;
                endcase
            end
            C_PROG: begin
                if (fail_i)      nst = C_ERR;
                else if (done_i) nst = C_READ;
            end
            C_TMO: begin
                if (wr_i && cb == CB_CONF) begin
                    add_en = 1'b1;
                end else if (wr_i && cb == CB_SUSP) begin
                    nst = C_SUSP; nph = PH_WIN; susp_n = 1'b1;
                end else if (rst_cmd) begin
                    nst = C_READ; clr_all = 1'b1; abort_n = 1'b1;
                end else if (tmo_exp) begin
                    nst = C_PREP; start_n = 1'b1; op_n = OP_ZERO; blk_n = cur;
                end
            end
            C_PREP, C_ERAS: begin
                if (wr_i && cb == CB_SUSP) begin
                    nst = C_SUSP; susp_n = 1'b1;
                    nph = (st == C_PREP) ? PH_ZERO : PH_ONES;
                end else if (rst_cmd) begin
                    nst = C_READ; clr_all = 1'b1; abort_n = 1'b1;
                    bad_n[cur] = 1'b1;
                end else if (fail_i) begin
                    nst = C_ERR;
                end else if (done_i) begin
                    if (st == C_PREP) begin
                        nst = C_ERAS; start_n = 1'b1; op_n = OP_ONES; blk_n = cur;
                    end else begin
                        del_en = 1'b1;
                        bad_n[cur] = 1'b0;
                        if (last) nst = C_READ;
                        else begin
                            nst = C_PREP; start_n = 1'b1; op_n = OP_ZERO; blk_n = nxt;
                        end
                    end
                end
            end
            C_SUSP: begin
                if (rst_cmd) begin
                    nst = C_READ; clr_all = 1'b1; abort_n = 1'b1;
                    bad_n[cur] = 1'b1;
                end else if (wr_i && dec_idle && cb == CB_CONF) begin
                    start_n = 1'b1; blk_n = cur;
                    if (ph == PH_ONES) begin nst = C_ERAS; op_n = OP_ONES; end
                    else               begin nst = C_PREP; op_n = OP_ZERO; end
                end else begin
                    unique case (ev)
                        EV_PROG: begin
                            if (set_v[blk_in]) abort_n = 1'b1;
                            else begin
                                nst = C_SPRG; start_n = 1'b1; op_n = OP_WORD; blk_n = blk_in;
                            end
                        end
                        EV_BAD:  abort_n = 1'b1;
                        default: ;
                    endcase
                end
            end
            C_SPRG: begin
                if (fail_i)      nst = C_ERR;
                else if (done_i) nst = C_SUSP;
            end
            C_ERR: begin
                if (rst_cmd) begin
                    nst = C_READ; clr_all = 1'b1;
                end
            end
            default: nst = C_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= C_READ;
            ph      <= PH_WIN;
            start_o <= 1'b0;
            susp_o  <= 1'b0;
            abort_o <= 1'b0;
            op_q    <= OP_NONE;
            blk_q   <= '0;
            bad_q   <= '0;
        end else begin
            st      <= nst;
            ph      <= nph;
            start_o <= start_n;
            susp_o  <= susp_n;
            abort_o <= abort_n;
            op_q    <= op_n;
            blk_q   <= blk_n;
            bad_q   <= bad_n;
        end
    end

    always_comb begin
        unique case (st)
            C_READ:  mode_o = MD_READ;
            C_SUSP:  mode_o = MD_SUSP;
            C_ERR:   mode_o = MD_STAT;
            default: mode_o = MD_BUSY;
        endcase
    end

    assign op_o  = op_q;
    assign blk_o = blk_q;
    assign bad_o = bad_q;

endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
    parameter int BLK_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_i,
    input logic                  done_i,
    input logic                  fail_i,
    input logic [1:0]            mode_o,
    input logic                  start_o,
    input logic [1:0]            op_o,
    input logic                  susp_o,
    input logic                  abort_o,
    input logic [(1<<BLK_W)-1:0] bad_o
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> mode_o == 2'd1);

    // R8
    susp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> mode_o == 2'd2);

    // R8
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && susp_o));

    // R11
    bad_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bad_o & ~$past(bad_o)) != '0) |-> abort_o);

    // R12
    stat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && $past(mode_o) != 2'd3) |-> $past(fail_i));

    // R6
    ones_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && op_o == 2'd3) |-> ($past(done_i) || $past(wr_i)));

endmodule

bind fcmd_top fcmd_chk #(.BLK_W(BLK_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .done_i  (done_i),
    .fail_i  (fail_i),
    .mode_o  (mode_o),
    .start_o (start_o),
    .op_o    (op_o),
    .susp_o  (susp_o),
    .abort_o (abort_o),
    .bad_o   (bad_o)
);

// File: tb/fcmd_top_tb.sv
`timescale 1ns/1ps
module fcmd_top_tb;

    localparam int TMO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [15:0] data_i = '0;
    logic        done_i = 1'b0;
    logic        fail_i = 1'b0;
    logic [1:0]  mode_o;
    logic        start_o;
    logic [1:0]  op_o;
    logic [2:0]  blk_o;
    logic        susp_o;
    logic        abort_o;
    logic [7:0]  bad_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0] exp_q[$];

    always #2.5 clk = ~clk;

    fcmd_top #(.ADDR_W(16), .BLK_W(3), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
        .done_i(done_i), .fail_i(fail_i), .mode_o(mode_o), .start_o(start_o),
        .op_o(op_o), .blk_o(blk_o), .susp_o(susp_o), .abort_o(abort_o), .bad_o(bad_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every start pulse must match the next expected item
    always @(negedge clk) begin
        if (rst_n && start_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R6 unexpected start", {op_o, blk_o}, 0);
            end else begin
                logic [4:0] e;
                e = exp_q.pop_front();
                chk({op_o, blk_o} == e, "R2/R6 start op/blk", {op_o, blk_o}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    function automatic logic [2:0] ablk(input logic [15:0] a);
        return a[15:13];
    endfunction

    task automatic push(input logic [1:0] op, input logic [2:0] b);
        exp_q.push_back({op, b});
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; data_i = d;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h2A54, 16'h00AA);
        wr(16'h1554, 16'h0055);
    endtask

    task automatic pulse_done();
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
    endtask

    task automatic erase_blk(input logic [15:0] a);
        unlock(); wr(16'h1554, 16'h0080);
        unlock(); wr(a, 16'h0030);
    endtask

    task automatic wait_start(output int n);
        n = 0;
        while (!start_o && n < 1000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mode_o == 2'd0, "R1 mode", mode_o, 0);
        chk(!start_o && !susp_o && !abort_o, "R1 strobes", {start_o, susp_o, abort_o}, 0);
        chk(bad_o == 8'h00, "R1 bad", bad_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 program word
        unlock(); wr(16'h2A54, 16'h00A0);
        push(2'd1, ablk(16'h3000));
        wr(16'h3000, 16'h1234);
        chk(mode_o == 2'd1, "R2 busy", mode_o, 1);
        pulse_done();
        chk(mode_o == 2'd0, "R2 back to read", mode_o, 0);

        // R3 malformed sequences
        wr(16'h2A54, 16'h00AA); wr(16'h0001, 16'h0055);
        chk(abort_o == 1'b1, "R3 bad unlock addr", abort_o, 1);
        chk(mode_o == 2'd0, "R3 mode", mode_o, 0);
        unlock(); wr(16'h1554, 16'h0080); unlock(); wr(16'h1554, 16'h0020);
        chk(abort_o == 1'b1, "R3 bad confirm", abort_o, 1);

        // R5 window restart, R6 order, R7 ignored write
        erase_blk(16'h4000);
        chk(mode_o == 2'd1, "R5 window busy", mode_o, 1);
        repeat (3) @(negedge clk);
        push(2'd2, 3'd2); push(2'd3, 3'd2); push(2'd2, 3'd5); push(2'd3, 3'd5);
        wr(16'hA000, 16'h0030);
        wait_start(n);
        chk(n == TMO, "R5 window length", n, TMO);
        wr(16'h2A54, 16'h00AA);
        chk(mode_o == 2'd1 && !abort_o, "R7 ignored write", {mode_o, abort_o}, 2);
        pulse_done(); pulse_done(); pulse_done(); pulse_done();
        chk(mode_o == 2'd0, "R6 done to read", mode_o, 0);

        // R8 R9 R10 suspend during erase
        push(2'd2, 3'd3);
        erase_blk(16'h6000);
        wait_start(n);
        push(2'd3, 3'd3);
        pulse_done();
        wr(16'h0000, 16'h00B0);
        chk(susp_o == 1'b1 && mode_o == 2'd2, "R8 suspend", {susp_o, mode_o}, 6);
        unlock(); wr(16'h2A54, 16'h00A0); wr(16'h6100, 16'h1111);
        chk(abort_o == 1'b1 && mode_o == 2'd2, "R10 reject same block", {abort_o, mode_o}, 6);
        unlock(); wr(16'h1554, 16'h0080);
        chk(abort_o == 1'b1 && mode_o == 2'd2, "R9 erase enable rejected", {abort_o, mode_o}, 6);
        push(2'd1, 3'd0);
        unlock(); wr(16'h2A54, 16'h00A0); wr(16'h0100, 16'h2222);
        chk(mode_o == 2'd1, "R10 program in suspend", mode_o, 1);
        pulse_done();
        chk(mode_o == 2'd2, "R10 back to suspend", mode_o, 2);
        push(2'd3, 3'd3);
        wr(16'h0000, 16'h0030);
        chk(mode_o == 2'd1, "R9 resumed", mode_o, 1);
        pulse_done();
        chk(mode_o == 2'd0, "R9 finished", mode_o, 0);

        // R8 suspend in window, R11 abort marks bad
        erase_blk(16'h8000);
        wr(16'h0000, 16'h00B0);
        chk(susp_o == 1'b1 && mode_o == 2'd2, "R8 window suspend", {susp_o, mode_o}, 6);
        repeat (TMO + 4) @(negedge clk);
        chk(mode_o == 2'd2, "R8 no start while suspended", mode_o, 2);
        wr(16'h0000, 16'h00F0);
        chk(abort_o == 1'b1 && mode_o == 2'd0, "R11 abort in suspend", {abort_o, mode_o}, 4);
        chk(bad_o == 8'h10, "R11 bad block 4", bad_o, 8'h10);

        // R11 abort during running pre-program
        push(2'd2, 3'd1);
        erase_blk(16'h2000);
        wait_start(n);
        wr(16'h0000, 16'h00F0);
        chk(abort_o == 1'b1 && mode_o == 2'd0, "R11 abort while running", {abort_o, mode_o}, 4);
        chk(bad_o == 8'h12, "R11 bad block 1", bad_o, 8'h12);

        // R12 failure
        push(2'd1, 3'd6);
        unlock(); wr(16'h2A54, 16'h00A0); wr(16'hC000, 16'h3333);
        @(negedge clk); fail_i = 1'b1; @(negedge clk); fail_i = 1'b0;
        chk(mode_o == 2'd3, "R12 status", mode_o, 3);
        wr(16'h0000, 16'h0030); wr(16'h2A54, 16'h00AA);
        chk(mode_o == 2'd3, "R12 stays status", mode_o, 3);
        wr(16'h0000, 16'h00F0);
        chk(mode_o == 2'd0, "R12 reset to read", mode_o, 0);

        // R4 chip erase with upper byte ignored, R6 walk, R11 bad cleared
        for (int b = 0; b < 8; b++) begin
            push(2'd2, 3'(b)); push(2'd3, 3'(b));
        end
        unlock(); wr(16'h1554, 16'h5580); unlock(); wr(16'h1554, 16'h0010);
        chk(start_o == 1'b1 && mode_o == 2'd1, "R4 chip erase start", {start_o, mode_o}, 3);
        for (int b = 0; b < 8; b++) begin
            pulse_done(); pulse_done();
        end
        chk(mode_o == 2'd0, "R4 chip erase done", mode_o, 0);
        chk(bad_o == 8'h00, "R11 bad cleared", bad_o, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all starts seen", exp_q.size(), 0);
        finish_run();
    end

endmodule